// File: doc/BRIEF.md
# Burst Acquisition Controller

This block is the host-side master for an external four-channel sampling converter. The converter holds all four inputs at once on the rising edge of an active-low start pulse. It converts them one after another and then pulls an active-low interrupt line low. On a periodic timer tick or a software request, the controller issues a start pulse whose low width is programmable. It then waits for the interrupt and runs exactly four read cycles to the same address, because the converter steps its own internal word pointer on each read.

Each read cycle has three programmable phases: chip select low with the read strobe still high (setup), then the read strobe low, then both high between reads (gap). The four 12-bit two's complement words are sign-extended to 16 bits. Each word is tagged with its channel index, and the set of four is presented as one result on a valid/ready output. If the interrupt does not arrive within a programmable number of cycles, the sequence is abandoned with an error pulse. A timer tick that arrives while a sequence is running is dropped and flagged as an overrun.

Top module: `burst_acq`

## Requirements
- R1: During and directly after reset, startN, csN and rdN are high and outValid is low.
- R2: A tickIn or swReq seen while idle makes startN go low for max(pulseWidth,1) cycles. startN is driven from a register and then returns high.
- R3: While a sequence is running (from the start pulse until the result is accepted or the sequence times out), no new start pulse is issued. A tickIn in that time produces a one-cycle overrun pulse and is dropped. A swReq in that time is dropped without a flag.
- R4: Between the rising edge of startN and the cycle in which irqN is seen low, csN and rdN stay high.
- R5: Each read cycle holds csN low with rdN high for max(setupWidth,1) cycles, then rdN low (csN still low) for max(strobeWidth,1) cycles. dataIn is captured at the clock edge that ends the strobe.
- R6: Consecutive reads are separated by max(gapWidth,1) cycles with csN and rdN high. Exactly four reads are made per sequence.
- R7: outData carries four 18-bit lanes. Lane k occupies bits [18k+17:18k] and holds {k as 2 bits, the k-th read word sign-extended from 12 to 16 bits}. Lane 0 comes from the first read. outValid rises on the same edge that ends the fourth strobe.
- R8: While outValid is high and outReady is low, outValid and outData hold steady. The edge on which both are high returns the block to idle.
- R9: If irqN is still high max(timeoutLimit,1) cycles after startN rises, timeoutErr pulses for one cycle and the block returns to idle with no read and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Periodic timer request |
| swReq | input | 1 | Software request |
| pulseWidth | input | 8 | Start pulse low width in cycles (0 acts as 1) |
| setupWidth | input | 8 | Chip-select-to-strobe setup in cycles (0 acts as 1) |
| strobeWidth | input | 8 | Read strobe low width in cycles (0 acts as 1) |
| gapWidth | input | 8 | Idle cycles between reads (0 acts as 1) |
| timeoutLimit | input | 16 | Cycles allowed for the interrupt (0 acts as 1) |
| startN | output | 1 | Active-low start pulse to the converter |
| irqN | input | 1 | Active-low conversion-done interrupt |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read strobe |
| dataIn | input | 12 | Converter data bus |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result accepted |
| outData | output | 72 | Four tagged 18-bit lanes |
| timeoutErr | output | 1 | One-cycle pulse on interrupt timeout |
| overrun | output | 1 | One-cycle pulse when a tick is dropped |

## Verification
All strobe outputs are registered from the next state. A request sampled at one edge therefore pulls startN low on that same edge. startN then rises exactly max(pulseWidth,1) edges later. The bench's converter model counts negedge samples of each low or high run and compares them with the clamped widths. outValid must already be high at the first negedge after rdN rises on the fourth read. The timeout error must appear at the negedge that comes max(timeoutLimit,1) negedges after the one where startN is first seen high. Overrun is checked at the next negedge after the tick is presented. Result holding is checked after a random number of cycles with outReady low.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WAIT, S_SETUP, S_STROBE, S_GAP, S_DONE
  } acqState_t;

  typedef struct packed {
    logic capture;
  } dpCtl_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             swReq,
  input  logic [CNT_W-1:0] pulseWidth,
  input  logic [CNT_W-1:0] setupWidth,
  input  logic [CNT_W-1:0] strobeWidth,
  input  logic [CNT_W-1:0] gapWidth,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             irqN,
  input  logic             outReady,
  output logic             startN,
  output logic             csN,
  output logic             rdN,
  output logic             outValid,
  output logic             timeoutErr,
  output logic             overrun,
  output dpCtl_t           dpCtl
);
  localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANES - 1);

  acqState_t state, nextState;
  logic [TO_W-1:0]   cnt, nextCnt;
  logic [SLOT_W-1:0] slot, nextSlot;
  logic              capture, errNow;

  // Load value for a down-counter: width minus one, a zero width acts as one.
  function automatic logic [TO_W-1:0] loadOf(input logic [CNT_W-1:0] w);
    return (w == '0) ? '0 : TO_W'(w - CNT_W'(1));
  endfunction

  always_comb begin
    nextState = state;
    nextCnt   = (cnt == '0) ? cnt : cnt - TO_W'(1);
    nextSlot  = slot;
    capture   = 1'b0;
    errNow    = 1'b0;
    unique case (state)
      S_IDLE: if (tickIn || swReq) begin
        nextState = S_START;
        nextCnt   = loadOf(pulseWidth);
      end
      S_START: if (cnt == '0) begin
        nextState = S_WAIT;
        nextCnt   = (timeoutLimit == '0) ? '0 : timeoutLimit - TO_W'(1);
      end
      S_WAIT: begin
        if (!irqN) begin
          nextState = S_SETUP;
          nextCnt   = loadOf(setupWidth);
          nextSlot  = '0;
        end else if (cnt == '0) begin
          nextState = S_IDLE;
          errNow    = 1'b1;
        end
      end
      S_SETUP: if (cnt == '0) begin
        nextState = S_STROBE;
        nextCnt   = loadOf(strobeWidth);
      end
      S_STROBE: if (cnt == '0) begin
        capture = 1'b1;
        if (slot == LAST_SLOT) begin
          nextState = S_DONE;
        end else begin
          nextState = S_GAP;
          nextCnt   = loadOf(gapWidth);
        end
      end
      S_GAP: if (cnt == '0) begin
        nextState = S_SETUP;
        nextCnt   = loadOf(setupWidth);
        nextSlot  = slot + SLOT_W'(1);
      end
      S_DONE: if (outReady) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      slot       <= '0;
      startN     <= 1'b1;
      csN        <= 1'b1;
      rdN        <= 1'b1;
      outValid   <= 1'b0;
      timeoutErr <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      state      <= nextState;
      cnt        <= nextCnt;
      slot       <= nextSlot;
      startN     <= (nextState != S_START);
      csN        <= !(nextState == S_SETUP || nextState == S_STROBE);
      rdN        <= (nextState != S_STROBE);
      outValid   <= (nextState == S_DONE);
      timeoutErr <= errNow;
      overrun    <= tickIn && (state != S_IDLE);
    end
  end

  assign dpCtl.capture = capture;
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int LANES    = 4,
  parameter int TAG_W    = 2,
  parameter int OUT_W    = LANES * (WORD_W + TAG_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              dpCtl,
  input  logic [SAMPLE_W-1:0] dataIn,
  output logic [OUT_W-1:0]    outData
);
  localparam int LANE_W = WORD_W + TAG_W;

  logic [WORD_W-1:0] lane [LANES];
  logic [WORD_W-1:0] extended;

  assign extended = {{(WORD_W - SAMPLE_W){dataIn[SAMPLE_W-1]}}, dataIn};

  // Shift register: after LANES captures, lane 0 holds the first read word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LANES; k++) lane[k] <= '0;
    end else if (dpCtl.capture) begin
      for (int k = 0; k < LANES - 1; k++) lane[k] <= lane[k+1];
      lane[LANES-1] <= extended;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign outData[k*LANE_W +: LANE_W] = {TAG_W'(k), lane[k]};
  end
endmodule

// File: rtl/burst_acq.sv
module burst_acq
  import acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16,
  parameter int LANES    = 4,
  parameter int CNT_W    = 8,
  parameter int TO_W     = 16,
  localparam int TAG_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int OUT_W   = LANES * (WORD_W + TAG_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                swReq,
  input  logic [CNT_W-1:0]    pulseWidth,
  input  logic [CNT_W-1:0]    setupWidth,
  input  logic [CNT_W-1:0]    strobeWidth,
  input  logic [CNT_W-1:0]    gapWidth,
  input  logic [TO_W-1:0]     timeoutLimit,
  output logic                startN,
  input  logic                irqN,
  output logic                csN,
  output logic                rdN,
  input  logic [SAMPLE_W-1:0] dataIn,
  output logic                outValid,
  input  logic                outReady,
  output logic [OUT_W-1:0]    outData,
  output logic                timeoutErr,
  output logic                overrun
);
  dpCtl_t dpCtl;

  acq_ctrl #(.LANES(LANES), .CNT_W(CNT_W), .TO_W(TO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .swReq(swReq),
    .pulseWidth(pulseWidth), .setupWidth(setupWidth),
    .strobeWidth(strobeWidth), .gapWidth(gapWidth),
    .timeoutLimit(timeoutLimit), .irqN(irqN), .outReady(outReady),
    .startN(startN), .csN(csN), .rdN(rdN), .outValid(outValid),
    .timeoutErr(timeoutErr), .overrun(overrun), .dpCtl(dpCtl)
  );

  acq_datapath #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .LANES(LANES),
                 .TAG_W(TAG_W), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .dataIn(dataIn), .outData(outData)
  );
endmodule

// File: rtl/burst_acq_checker.sv
module burst_acq_checker #(
  parameter int OUT_W = 72
) (
  input logic             clk,
  input logic             rstN,
  input logic             startN,
  input logic             irqN,
  input logic             csN,
  input logic             rdN,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic             timeoutErr
);
  logic prevStartN, converting, busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStartN <= 1'b1;
      converting <= 1'b0;
      busy       <= 1'b0;
    end else begin
      prevStartN <= startN;
      if (!irqN)                      converting <= 1'b0;
      else if (startN && !prevStartN) converting <= 1'b1;
      if (!startN && prevStartN)                  busy <= 1'b1;
      else if ((outValid && outReady) || timeoutErr) busy <= 1'b0;
    end
  end

  AST_NO_READ_IN_CONV: assert property (@(posedge clk) disable iff (!rstN)
    converting |-> (csN && rdN)) else $error("read during conversion"); // R4

  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !csN) else $error("strobe without select"); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))) else $error("result dropped"); // R8

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startN) |-> !busy) else $error("start while busy"); // R3

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr) else $error("long error pulse"); // R9

  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !outValid) else $error("error with result"); // R9
endmodule

bind burst_acq burst_acq_checker #(.OUT_W(OUT_W)) checker_i (
  .clk(clk), .rstN(rstN), .startN(startN), .irqN(irqN), .csN(csN), .rdN(rdN),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .timeoutErr(timeoutErr)
);

// File: tb/burst_acq_tb_top.sv
module burst_acq_tb_top;
  localparam int OW = 72;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, tickIn, swReq, irqN, outReady;
  logic [7:0] pulseWidth, setupWidth, strobeWidth, gapWidth;
  logic [15:0] timeoutLimit;
  logic [11:0] dataIn;
  logic startN, csN, rdN, outValid, timeoutErr, overrun;
  logic [OW-1:0] outData;

  burst_acq dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .swReq(swReq),
    .pulseWidth(pulseWidth), .setupWidth(setupWidth), .strobeWidth(strobeWidth),
    .gapWidth(gapWidth), .timeoutLimit(timeoutLimit), .startN(startN),
    .irqN(irqN), .csN(csN), .rdN(rdN), .dataIn(dataIn), .outValid(outValid),
    .outReady(outReady), .outData(outData), .timeoutErr(timeoutErr), .overrun(overrun)
  );

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic logic [17:0] laneOf(input int k, input logic [11:0] v);
    return {k[1:0], {4{v[11]}}, v};
  endfunction

  // Converter model and strobe measurement, all at negedge.
  bit respond = 1'b1;
  int lat = 3;
  logic [11:0] smp [4];
  int rdIdx = 0, startCount = 0, overrunCount = 0, convRead = 0;
  int startRun = 0, lastStartLow = 0, setupRun = 0, rdRun = 0, gapRun = 0, latCnt = 0;
  int setupMeas [4], rdMeas [4], gapMeas [3];
  bit gapping = 1'b0, converting = 1'b0;
  logic prevStart = 1'b1, prevRd = 1'b1;

  initial begin
    irqN = 1'b1;
    dataIn = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (converting && !csN) convRead++;
        if (prevStart && !startN) startCount++;
        if (!startN) startRun++;
        if (!prevStart && startN) begin
          lastStartLow = startRun;
          startRun = 0;
          rdIdx = 0;
          if (respond) begin converting = 1'b1; latCnt = lat; end
        end
        if (converting) begin
          latCnt--;
          if (latCnt <= 0) begin irqN = 1'b0; converting = 1'b0; end
        end
        if (gapping) begin
          if (csN) gapRun++;
          else begin
            if (rdIdx >= 1 && rdIdx <= 3) gapMeas[rdIdx-1] = gapRun;
            gapping = 1'b0;
          end
        end
        if (!csN && rdN) setupRun++;
        if (prevRd && !rdN) begin
          if (rdIdx < 4) begin setupMeas[rdIdx] = setupRun; dataIn = smp[rdIdx]; end
          rdIdx++;
          setupRun = 0;
          irqN = 1'b1;
        end
        if (!rdN) rdRun++;
        if (!prevRd && rdN) begin
          if (rdIdx >= 1 && rdIdx <= 4) rdMeas[rdIdx-1] = rdRun;
          rdRun = 0;
          chk(outValid == (rdIdx == 4), "R7 outValid with end of strobe", outValid, rdIdx == 4);
          if (rdIdx < 4) begin gapping = 1'b1; gapRun = 1; end
        end
        if (overrun) overrunCount++;
        prevStart = startN;
        prevRd = rdN;
      end
    end
  end

  task automatic runSeq(input int p, input int s, input int st, input int g, input int l,
                        input int rdy, input bit useTick, input bit busyTick, input bit busySw);
    int n;
    logic [OW-1:0] keep;
    pulseWidth = 8'(p); setupWidth = 8'(s); strobeWidth = 8'(st); gapWidth = 8'(g);
    timeoutLimit = 16'd500;
    lat = l; respond = 1'b1;
    startCount = 0; overrunCount = 0; convRead = 0;
    @(negedge clk);
    if (useTick) tickIn = 1'b1; else swReq = 1'b1;
    @(negedge clk);
    tickIn = 1'b0; swReq = 1'b0;
    if (busyTick || busySw) begin
      repeat (2) @(negedge clk);
      tickIn = busyTick; swReq = busySw;
      @(negedge clk);
      tickIn = 1'b0; swReq = 1'b0;
      chk(overrun == busyTick, "R3 overrun pulse for busy tick", overrun, busyTick);
    end
    n = 0;
    while (!outValid && n < 3000) begin @(negedge clk); n++; end
    chk(outValid, "R7 result produced", outValid, 1);
    for (int k = 0; k < 4; k++)
      chk(outData[k*18 +: 18] == laneOf(k, smp[k]), "R7 lane content",
          outData[k*18 +: 18], laneOf(k, smp[k]));
    chk(lastStartLow == eff(p), "R2 start pulse width", lastStartLow, eff(p));
    for (int k = 0; k < 4; k++) begin
      chk(setupMeas[k] == eff(s), "R5 setup width", setupMeas[k], eff(s));
      chk(rdMeas[k] == eff(st), "R5 strobe width", rdMeas[k], eff(st));
    end
    for (int k = 0; k < 3; k++)
      chk(gapMeas[k] == eff(g), "R6 gap width", gapMeas[k], eff(g));
    chk(startCount == 1, "R3 single start per sequence", startCount, 1);
    chk(overrunCount == int'(busyTick), "R3 overrun count", overrunCount, busyTick);
    chk(convRead == 0, "R4 no select during conversion", convRead, 0);
    keep = outData;
    repeat (rdy) @(negedge clk);
    chk(outValid && outData == keep, "R8 result held without ready", outValid, 1);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, "R8 released after ready", outValid, 0);
    repeat (3) @(negedge clk);
    chk(rdIdx == 4 && csN && startN, "R6 exactly four reads", rdIdx, 4);
  endtask

  task automatic runTimeout(input int t);
    int n;
    pulseWidth = 8'd2; setupWidth = 8'd1; strobeWidth = 8'd1; gapWidth = 8'd1;
    timeoutLimit = 16'(t);
    respond = 1'b0;
    @(negedge clk);
    swReq = 1'b1;
    @(negedge clk);
    swReq = 1'b0;
    n = 0;
    while (startN && n < 50) begin @(negedge clk); n++; end
    while (!startN && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (!timeoutErr && n < t + 20) begin @(negedge clk); n++; end
    chk(n == eff(t), "R9 timeout delay", n, eff(t));
    chk(rdIdx == 0 && !outValid, "R9 no read and no result", rdIdx, 0);
    @(negedge clk);
    chk(!timeoutErr && csN && startN, "R9 back to idle", timeoutErr, 0);
    respond = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; tickIn = 1'b0; swReq = 1'b0; outReady = 1'b0;
    pulseWidth = 8'd1; setupWidth = 8'd1; strobeWidth = 8'd1; gapWidth = 8'd1;
    timeoutLimit = 16'd500;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(startN && csN && rdN && !outValid, "R1 outputs in reset", {startN, csN, rdN, outValid}, 4'b1110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(startN && csN && rdN && !outValid, "R1 outputs after reset", {startN, csN, rdN, outValid}, 4'b1110);

    smp[0] = 12'h800; smp[1] = 12'h7FF; smp[2] = 12'hFFF; smp[3] = 12'h000;
    runSeq(1, 1, 1, 1, 2, 0, 1'b1, 1'b0, 1'b0);
    smp[0] = 12'h001; smp[1] = 12'hFFE; smp[2] = 12'h5A5; smp[3] = 12'hA5A;
    runSeq(0, 0, 0, 0, 3, 2, 1'b0, 1'b0, 1'b0);
    smp[0] = 12'h123; smp[1] = 12'h9AB; smp[2] = 12'h3C0; smp[3] = 12'hC03;
    runSeq(3, 2, 4, 5, 30, 1, 1'b1, 1'b1, 1'b0);
    runSeq(2, 3, 2, 2, 30, 0, 1'b0, 1'b0, 1'b1);
    runTimeout(25);
    runTimeout(0);
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 4; k++) smp[k] = 12'($urandom);
      runSeq(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
             int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
             int'($urandom_range(2, 12)), int'($urandom_range(0, 4)),
             1'($urandom), 1'b0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule